// File: doc/BRIEF.md
# Bridge ADC Serial Reader

This controller sits on the host side of a two-wire link to a pin-programmed weigh-scale converter. One wire is an output that serves as both serial clock and power-down control. The other is an input that carries both the ready indication and the serial data. A read starts with a one-cycle `start` strobe. At that moment the controller latches a 2-bit code that picks the channel and gain of the converter's *next* conversion. It then waits until the converter pulls the data line low. After that it generates the clock pulses and collects the 24-bit sample, most significant bit first. It finishes by adding one, two or three extra pulses; that count programs the following conversion.

The sample is two's complement. It comes out sign-extended to 32 bits, together with a one-cycle valid strobe and a flag that marks the two saturation codes. Both clock phases are timed by a divider of the system clock. The data input passes through a two-flop synchronizer. While the controller is idle, a level request holds the clock line high, which powers the converter down. An indication rises once the hold time has passed. Dropping the request releases the line, which wakes the converter with its default setting.

Top module: `bridge_adc_reader`

## Requirements
- R1: After reset, `adc_sck`, `busy`, `res_valid`, `res_sat` and `pd_active` are all 0.
- R2: After `start`, `busy` is 1 and `adc_sck` stays low for as long as the synchronized data line is high; no pulse is produced before the line goes low.
- R3: The 24 sampled bits are assembled MSB first: pulse k (1..24) presents bit 24-k. `result[23:0]` holds the sample and `result[31:24]` repeats bit 23.
- R4: The total pulse count of a read is 25 for code 0 (channel A, gain 128), 26 for code 1 (channel B, gain 32) and 27 for code 2 (channel A, gain 64). Code 3 gives 25.
- R5: During a read, every clock high phase and every low phase between pulses lasts exactly HALF_CYC system clocks.
- R6: `res_valid` is a one-cycle pulse issued when the low phase after the final pulse ends; `busy` is 0 in that cycle.
- R7: `res_sat` is 1 together with `res_valid` exactly when the sample is 800000h or 7FFFFFh, and is otherwise 0.
- R8: `sel_code` is latched only at `start` while idle; changing it during a read does not change that read's pulse count.
- R9: With `pd_req` high while idle, `adc_sck` goes high one cycle later and stays high. `pd_active` rises PD_CYC cycles after that, and `start` is ignored (`busy` stays 0).
- R10: Dropping `pd_req` brings `adc_sck` low and `pd_active` low within two cycles, and a following read completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to read a sample (taken while idle) |
| sel_code | input | 2 | Channel/gain code for the next conversion |
| pd_req | input | 1 | Level request to power the converter down |
| adc_sck | output | 1 | Serial clock / power-down line to the converter |
| adc_dout | input | 1 | Ready / serial data line from the converter |
| busy | output | 1 | A read is in progress |
| result | output | 32 | Sign-extended sample |
| res_valid | output | 1 | One-cycle strobe: `result` is new |
| res_sat | output | 1 | Sample is a saturation code (valid with `res_valid`) |
| pd_active | output | 1 | Clock line has been held high for the power-down time |

## Verification
The bound checker watches, on every cycle, that the valid strobe lasts one cycle and never overlaps `busy`. It also checks that the upper result byte copies the sign bit, that the saturation flag appears only with a saturation code, that no clock high phase during a read outlasts HALF_CYC, and that the line stays high while power-down is reported. Other properties need a model of the converter, so only the bench scenarios can show them. These are the exact pulse count for each code, the MSB-first bit order, that no pulse is produced before ready, that the latched code ignores later changes, and the power-down entry and wake-up sequence.

// File: rtl/bar_pkg.sv
package bar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAITR, ST_LOW, ST_HIGH, ST_PDOWN
  } rd_state_t;

  localparam int DATA_BITS = 24;

  // extra pulses after the data bits; code 3 falls back to the default
  function automatic logic [1:0] trail_pulses(input logic [1:0] code);
    case (code)
      2'd1:    trail_pulses = 2'd2;
      2'd2:    trail_pulses = 2'd3;
      default: trail_pulses = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/bar_sync2.sv
module bar_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic s1;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/bar_countdown.sv
module bar_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end
  assign done = (cnt == '0);
endmodule

// File: rtl/bar_result.sv
module bar_result #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] result,
  output logic             res_valid,
  output logic             res_sat
);
  localparam logic [IN_W-1:0] NEG_SAT = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [IN_W-1:0] POS_SAT = {1'b0, {(IN_W-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      res_valid <= 1'b0;
      res_sat   <= 1'b0;
    end else begin
      res_valid <= load;
      res_sat   <= load && (raw == NEG_SAT || raw == POS_SAT);
      if (load) result <= {{(OUT_W-IN_W){raw[IN_W-1]}}, raw};
    end
  end
endmodule

// File: rtl/bridge_adc_reader.sv
module bridge_adc_reader #(
  parameter int HALF_CYC = 25,
  parameter int PD_CYC   = 6100,
  parameter int OUT_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       sel_code,
  input  logic             pd_req,
  output logic             adc_sck,
  input  logic             adc_dout,
  output logic             busy,
  output logic [OUT_W-1:0] result,
  output logic             res_valid,
  output logic             res_sat,
  output logic             pd_active
);
  import bar_pkg::*;

  localparam int PW = $clog2(HALF_CYC + 1);
  localparam int DW = $clog2(PD_CYC + 1);
  localparam logic [PW-1:0] PH_LOAD = PW'(HALF_CYC - 1);
  localparam logic [DW-1:0] PD_LOAD = DW'(PD_CYC - 1);

  rd_state_t state;
  logic [1:0]           code_q;
  logic [4:0]           pcnt;
  logic [DATA_BITS-1:0] shreg;
  logic                 din_s, ph_done, pd_done;
  logic                 ph_load, pd_load, fin;
  logic [4:0]           total;

  assign total   = 5'(DATA_BITS) + {3'b0, trail_pulses(code_q)};
  assign ph_load = (state == ST_WAITR && !din_s) ||
                   ((state == ST_LOW || state == ST_HIGH) && ph_done);
  assign pd_load = (state == ST_IDLE) && pd_req;
  assign fin     = (state == ST_LOW) && ph_done && (pcnt == total);
  assign busy    = (state == ST_WAITR) || (state == ST_LOW) || (state == ST_HIGH);

  bar_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(adc_dout), .q(din_s));

  bar_countdown #(.W(PW)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(PH_LOAD), .done(ph_done));

  bar_countdown #(.W(DW)) u_pdtmr (
    .clk(clk), .rst(rst), .load(pd_load), .load_val(PD_LOAD), .done(pd_done));

  bar_result #(.IN_W(DATA_BITS), .OUT_W(OUT_W)) u_res (
    .clk(clk), .rst(rst), .load(fin), .raw(shreg),
    .result(result), .res_valid(res_valid), .res_sat(res_sat));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      adc_sck   <= 1'b0;
      code_q    <= 2'd0;
      pcnt      <= '0;
      shreg     <= '0;
      pd_active <= 1'b0;
    end else begin
      pd_active <= (state == ST_PDOWN) && pd_done && pd_req;
      case (state)
        ST_IDLE: begin
          adc_sck <= 1'b0;
          if (pd_req) begin
            state   <= ST_PDOWN;
            adc_sck <= 1'b1;
          end else if (start) begin
            code_q <= sel_code;
            pcnt   <= '0;
            state  <= ST_WAITR;
          end
        end
        ST_WAITR: if (!din_s) state <= ST_LOW;
        ST_LOW: if (ph_done) begin
          if (pcnt >= 5'd1 && pcnt <= 5'(DATA_BITS))
            shreg <= {shreg[DATA_BITS-2:0], din_s};
          if (pcnt == total) begin
            state <= ST_IDLE;
          end else begin
            state   <= ST_HIGH;
            adc_sck <= 1'b1;
            pcnt    <= pcnt + 5'd1;
          end
        end
        ST_HIGH: if (ph_done) begin
          state   <= ST_LOW;
          adc_sck <= 1'b0;
        end
        ST_PDOWN: if (!pd_req) begin
          state   <= ST_IDLE;
          adc_sck <= 1'b0;
          code_q  <= 2'd0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bar_checker.sv
module bar_checker #(
  parameter int HALF_CYC = 25,
  parameter int OUT_W    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             adc_sck,
  input logic             busy,
  input logic [OUT_W-1:0] result,
  input logic             res_valid,
  input logic             res_sat,
  input logic             pd_active
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst || !adc_sck)     hi_cnt <= '0;
    else if (hi_cnt != '1)   hi_cnt <= hi_cnt + 16'd1;
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !busy);
  // R3
  sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (result[OUT_W-1:23] == {(OUT_W-23){result[23]}}));
  // R7
  sat_qual_chk: assert property (@(posedge clk) disable iff (rst)
    res_sat |-> res_valid &&
      (result[23:0] == 24'h800000 || result[23:0] == 24'h7FFFFF));
  // R5
  hi_width_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> hi_cnt <= 16'(HALF_CYC));
  // R9
  pd_high_chk: assert property (@(posedge clk) disable iff (rst)
    pd_active |-> adc_sck);
endmodule

bind bridge_adc_reader bar_checker #(.HALF_CYC(HALF_CYC), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .adc_sck(adc_sck), .busy(busy), .result(result),
  .res_valid(res_valid), .res_sat(res_sat), .pd_active(pd_active));

// File: tb/bridge_adc_reader_test.sv
`timescale 1ns/1ps
module bridge_adc_reader_test;
  localparam int HALF = 25;
  localparam int PDC  = 6100;

  logic clk = 0, rst = 1, start = 0, pd_req = 0, adc_dout = 1;
  logic [1:0] sel_code = 0;
  logic adc_sck, busy, res_valid, res_sat, pd_active;
  logic [31:0] result;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  bridge_adc_reader #(.HALF_CYC(HALF), .PD_CYC(PDC)) uut (
    .clk(clk), .rst(rst), .start(start), .sel_code(sel_code), .pd_req(pd_req),
    .adc_sck(adc_sck), .adc_dout(adc_dout), .busy(busy), .result(result),
    .res_valid(res_valid), .res_sat(res_sat), .pd_active(pd_active));

  // converter model
  logic [23:0] smp;
  int pc = 0;
  always @(posedge adc_sck) begin
    pc++;
    #1;
    if (pc <= 24) adc_dout = smp[24-pc];
    else          adc_dout = 1'b1;
  end

  // pulse width monitor
  time t_rise = 0, t_fall = 0;
  logic fall_seen = 0;
  int hi_min = 1000000, hi_max = 0, lo_min = 1000000, lo_max = 0;
  always @(posedge adc_sck) begin
    if (fall_seen) begin
      lo_min = (int'((($time - t_fall))/10) < lo_min) ? int'(($time - t_fall)/10) : lo_min;
      lo_max = (int'((($time - t_fall))/10) > lo_max) ? int'(($time - t_fall)/10) : lo_max;
    end
    t_rise = $time;
  end
  always @(negedge adc_sck) begin
    hi_min = (int'(($time - t_rise)/10) < hi_min) ? int'(($time - t_rise)/10) : hi_min;
    hi_max = (int'(($time - t_rise)/10) > hi_max) ? int'(($time - t_rise)/10) : hi_max;
    t_fall = $time;
    fall_seen = 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic make_ready(input logic [23:0] d);
    smp = d; pc = 0; adc_dout = 1'b0;
    fall_seen = 0; hi_min = 1000000; hi_max = 0; lo_min = 1000000; lo_max = 0;
  endtask

  task automatic issue_start(input logic [1:0] code);
    @(negedge clk); sel_code = code; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_result(output bit got, output logic [31:0] r, output logic s);
    got = 0; r = 0; s = 0;
    for (int i = 0; i < 5000 && !got; i++) begin
      @(negedge clk);
      if (res_valid) begin got = 1; r = result; s = res_sat; end
    end
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(adc_sck == 0 && busy == 0, "R1 sck/busy", {adc_sck, busy}, 0);
    chk(res_valid == 0 && res_sat == 0 && pd_active == 0, "R1 flags",
        {res_valid, res_sat, pd_active}, 0);
  endtask

  task automatic t_read(input logic [23:0] d, input logic [1:0] code,
                        input logic [1:0] late_code, input int exp_pulses, input string tag);
    bit got; logic [31:0] r; logic s;
    logic [31:0] exp_r = {{8{d[23]}}, d};
    logic exp_s = (d == 24'h800000) || (d == 24'h7FFFFF);
    make_ready(d);
    issue_start(code);
    sel_code = late_code;
    wait_result(got, r, s);
    chk(got, {tag, " R6 valid seen"}, got, 1);
    chk(r == exp_r, {tag, " R3 result"}, r, exp_r);
    chk(s == exp_s, {tag, " R7 sat flag"}, s, exp_s);
    chk(busy == 0, {tag, " R6 busy low"}, busy, 0);
    @(negedge clk);
    chk(res_valid == 0, {tag, " R6 one-cycle valid"}, res_valid, 0);
    repeat (HALF * 2) @(negedge clk);
    chk(pc == exp_pulses, {tag, " R4/R8 pulse count"}, pc, exp_pulses);
    chk(hi_min == HALF && hi_max == HALF, {tag, " R5 high width"}, hi_max, HALF);
    chk(lo_min == HALF && lo_max == HALF, {tag, " R5 low width"}, lo_max, HALF);
    adc_dout = 1'b1;
  endtask

  task automatic t_wait_ready();
    bit got; logic [31:0] r; logic s;
    smp = 24'h0F0F0F; pc = 0; adc_dout = 1'b1;
    issue_start(2'd0);
    repeat (300) @(negedge clk);
    chk(busy == 1 && adc_sck == 0 && pc == 0, "R2 no pulse before ready",
        {busy, adc_sck, 8'(pc)}, 32'h2_00);
    make_ready(24'h0F0F0F);
    wait_result(got, r, s);
    chk(got && r == 32'h000F0F0F, "R2 read after ready", r, 32'h000F0F0F);
    repeat (HALF * 2) @(negedge clk);
    adc_dout = 1'b1;
  endtask

  task automatic t_powerdown();
    @(negedge clk); pd_req = 1;
    @(negedge clk);
    chk(adc_sck == 1, "R9 sck high", adc_sck, 1);
    start = 1; @(negedge clk); start = 0;
    repeat (8) @(negedge clk);
    chk(pd_active == 0 && busy == 0, "R9 early/start ignored", {pd_active, busy}, 0);
    repeat (PDC) @(negedge clk);
    chk(pd_active == 1 && adc_sck == 1, "R9 pd_active", {pd_active, adc_sck}, 3);
    pd_req = 0;
    repeat (2) @(negedge clk);
    chk(adc_sck == 0 && pd_active == 0, "R10 wake", {adc_sck, pd_active}, 0);
    t_read(24'h2468AC, 2'd0, 2'd0, 25, "R10 read after wake");
  endtask

  initial begin
    t_reset();
    t_read(24'h123456, 2'd0, 2'd0, 25, "code0");
    t_read(24'hABCDEF, 2'd1, 2'd1, 26, "code1");
    t_read(24'h7FFFFF, 2'd2, 2'd2, 27, "code2 possat");
    t_read(24'h800000, 2'd3, 2'd3, 25, "code3 negsat");
    t_read(24'h7FFFFE, 2'd0, 2'd0, 25, "near sat");
    t_read(24'hC00001, 2'd2, 2'd1, 27, "R8 late code change");
    t_wait_ready();
    t_powerdown();
    finish_run();
  end
endmodule